// File: doc/BRIEF.md
# Serial Constant Divider by 2^p+1

This block divides an unsigned dividend of any length by the fixed divisor 2^p+1. The dividend is streamed in as p-bit tuples, highest-order tuple first, over a valid/ready input with a last flag. For each accepted tuple the block emits one p-bit quotient tuple on a valid/ready output. The datapath has one subtract, a conditional decrement and a correcting add of the divisor. It has the same size for every dividend length, because each step needs only the held partial remainder and the incoming tuple.

When the last dividend tuple has been consumed, the integer remainder appears on a separate output, flagged valid. A fraction length, sampled together with the last tuple, sets how many fractional quotient tuples follow. These tuples are not produced by further division. They come from a two-tuple repeating pattern derived from the final remainder. Every output tuple carries a tag that marks it as integer or fractional. The first tuple of the next dividend starts a new division with a cleared remainder.

Top module: `const_div_serial`

## Requirements
- R1: For an accepted tuple T with held remainder R where T >= R, the quotient tuple is R and the new remainder is T - R.
- R2: For an accepted tuple T with T < R, the quotient tuple is R - 1 and the new remainder is T - R + 2^p + 1. The remainder always stays within 0..2^p.
- R3: After reset, q_valid_o and rem_valid_o are 0 and in_ready_o is 1. The first tuple of every division is combined with a remainder of zero, whatever the previous division left.
- R4: Once the tuple flagged in_last_i is accepted, rem_valid_o is 1 and rem_o holds the integer remainder, dividend mod (2^p+1), which lies in 0..2^p. Both hold until the first tuple of the next division is accepted.
- R5: For a nonzero final remainder R, the fractional tuples alternate R-1, then (2^p-1)-(R-1), starting with R-1. They carry q_frac_o = 1, while integer tuples carry q_frac_o = 0.
- R6: For a final remainder of zero, every fractional tuple is zero.
- R7: The number of fractional tuples equals frac_len_i as sampled with the last dividend tuple. A value of 0 produces no fractional tuple.
- R8: in_ready_o stays 0 while fractional tuples remain to be issued, so no tuple of a new division is accepted before the previous division's output is complete.
- R9: While q_valid_o is 1 and q_ready_i is 0, q_valid_o, q_tuple_o and q_frac_o hold. A stalled output also blocks input acceptance.
- R10: Dividends of any tuple count, including the longest the bench drives, give quotient tuples equal to the wide-integer quotient split into p-bit tuples, most significant first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Dividend tuple valid |
| in_ready_o | output | 1 | Dividend tuple accepted when high with valid |
| in_tuple_i | input | P | Dividend tuple, most significant first |
| in_last_i | input | 1 | Marks the least significant dividend tuple |
| frac_len_i | input | FLW | Number of fractional tuples, sampled with the last tuple |
| q_valid_o | output | 1 | Quotient tuple valid |
| q_ready_i | input | 1 | Consumer ready for quotient tuple |
| q_tuple_o | output | P | Quotient tuple |
| q_frac_o | output | 1 | 1 for a fractional tuple, 0 for an integer tuple |
| rem_o | output | P+1 | Integer remainder |
| rem_valid_o | output | 1 | rem_o holds the remainder of the completed division |

## Verification
The assertions check the following on every cycle:
- a stalled output holds its tuple and tag;
- the reported remainder stays within 0..2^p and holds while no new dividend enters;
- each fractional tuple is either R-1 or its p-bit complement, and is zero when R is zero;
- successive fractional tuples alternate.

Only the bench's scenarios can show the rest, using wide-integer division as the reference at p = 1, 4 and 7:
- the quotient and remainder values;
- the exact count of fractional tuples;
- the starting phase of the pattern;
- the clearing of the remainder between divisions;
- that input is refused while the fraction is being issued.

// File: rtl/cdiv_pkg.sv
package cdiv_pkg;
  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_RUN  = 2'd1,
    S_FRAC = 2'd2,
    S_DONE = 2'd3
  } cdiv_state_e;
endpackage

// File: rtl/cdiv_step.sv
// One long-division step in base 2^P by 2^P+1.
module cdiv_step #(
  parameter int P = 4
) (
  input  logic [P-1:0] tuple_i,
  input  logic [P:0]   rem_i,
  output logic [P-1:0] quo_o,
  output logic [P:0]   rem_o
);
  localparam logic [P:0] DIVR = (P+1)'((2 ** P) + 1);

  logic [P+1:0] diff;
  logic         borrow;

  assign diff   = {2'b00, tuple_i} - {1'b0, rem_i};
  assign borrow = diff[P+1];
  // rem_i == 2^P always borrows; low bits 0 minus 1 wrap to 2^P-1
  assign quo_o  = rem_i[P-1:0] - P'(borrow);
  assign rem_o  = borrow ? (diff[P:0] + DIVR) : diff[P:0];
endmodule

// File: rtl/cdiv_frac_gen.sv
// Fraction tuple from final remainder: R-1 on even phase, its complement on odd.
module cdiv_frac_gen #(
  parameter int P = 4
) (
  input  logic [P:0]   rem_i,
  input  logic         phase_i,
  output logic [P-1:0] tuple_o
);
  logic [P-1:0] first;

  assign first   = rem_i[P-1:0] - P'(1);
  assign tuple_o = (rem_i == '0) ? '0 : (phase_i ? ~first : first);
endmodule

// File: rtl/const_div_serial.sv
module const_div_serial
  import cdiv_pkg::*;
#(
  parameter int P   = 4,
  parameter int FLW = 8
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           in_valid_i,
  output logic           in_ready_o,
  input  logic [P-1:0]   in_tuple_i,
  input  logic           in_last_i,
  input  logic [FLW-1:0] frac_len_i,
  output logic           q_valid_o,
  input  logic           q_ready_i,
  output logic [P-1:0]   q_tuple_o,
  output logic           q_frac_o,
  output logic [P:0]     rem_o,
  output logic           rem_valid_o
);
  cdiv_state_e    state_q;
  logic [P:0]     rem_q;
  logic [FLW-1:0] cnt_q;
  logic           phase_q;
  logic           q_valid_q;
  logic [P-1:0]   q_tuple_q;
  logic           q_frac_q;

  logic           out_free;
  logic           acc;
  logic           frac_go;
  logic [P:0]     rem_use;
  logic [P-1:0]   step_quo;
  logic [P:0]     step_rem;
  logic [P-1:0]   frac_tuple;

  assign out_free   = !q_valid_q || q_ready_i;
  assign in_ready_o = out_free && (state_q != S_FRAC);
  assign acc        = in_valid_i && in_ready_o;
  assign frac_go    = (state_q == S_FRAC) && out_free;
  // a new division starts from a zero remainder
  assign rem_use    = (state_q == S_RUN) ? rem_q : '0;

  cdiv_step #(.P(P)) u_step (
    .tuple_i (in_tuple_i),
    .rem_i   (rem_use),
    .quo_o   (step_quo),
    .rem_o   (step_rem)
  );

  cdiv_frac_gen #(.P(P)) u_frac (
    .rem_i   (rem_q),
    .phase_i (phase_q),
    .tuple_o (frac_tuple)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= S_IDLE;
      rem_q     <= '0;
      cnt_q     <= '0;
      phase_q   <= 1'b0;
      q_valid_q <= 1'b0;
      q_tuple_q <= '0;
      q_frac_q  <= 1'b0;
    end else begin
      if (out_free) q_valid_q <= acc || frac_go;
      if (acc) begin
        rem_q     <= step_rem;
        q_tuple_q <= step_quo;
        q_frac_q  <= 1'b0;
        phase_q   <= 1'b0;
        cnt_q     <= frac_len_i;
        if (in_last_i) state_q <= (frac_len_i == '0) ? S_DONE : S_FRAC;
        else           state_q <= S_RUN;
      end else if (frac_go) begin
        q_tuple_q <= frac_tuple;
        q_frac_q  <= 1'b1;
        phase_q   <= ~phase_q;
        cnt_q     <= cnt_q - FLW'(1);
        if (cnt_q == FLW'(1)) state_q <= S_DONE;
      end
    end
  end

  assign q_valid_o   = q_valid_q;
  assign q_tuple_o   = q_tuple_q;
  assign q_frac_o    = q_frac_q;
  assign rem_o       = rem_q;
  assign rem_valid_o = (state_q == S_FRAC) || (state_q == S_DONE);
endmodule

// File: rtl/const_div_serial_chk.sv
module const_div_serial_chk #(
  parameter int P = 4
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         in_valid_i,
  input logic         in_ready_o,
  input logic         q_valid_o,
  input logic         q_ready_i,
  input logic [P-1:0] q_tuple_o,
  input logic         q_frac_o,
  input logic [P:0]   rem_o,
  input logic         rem_valid_o
);
  localparam logic [P:0] REM_MAX = (P+1)'(2 ** P);

  p_out_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    q_valid_o && !q_ready_i |=> q_valid_o && $stable(q_tuple_o) && $stable(q_frac_o));

  p_rem_range_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rem_valid_o |-> rem_o <= REM_MAX);

  p_rem_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rem_valid_o && !(in_valid_i && in_ready_o) |=> rem_valid_o && $stable(rem_o));

  p_frac_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    q_valid_o && q_frac_o && rem_o == '0 |-> q_tuple_o == '0);

  p_frac_pair_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    q_valid_o && q_frac_o && rem_o != '0 |->
      (q_tuple_o == rem_o[P-1:0] - P'(1)) || (q_tuple_o == ~(rem_o[P-1:0] - P'(1))));

  p_frac_alt_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    q_valid_o && q_ready_i && q_frac_o && rem_o != '0 |=>
      !q_valid_o || !q_frac_o || (q_tuple_o == ~$past(q_tuple_o)));

  p_frac_has_rem_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    q_valid_o && q_frac_o |-> rem_valid_o);
endmodule

bind const_div_serial const_div_serial_chk #(.P(P)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .in_valid_i  (in_valid_i),
  .in_ready_o  (in_ready_o),
  .q_valid_o   (q_valid_o),
  .q_ready_i   (q_ready_i),
  .q_tuple_o   (q_tuple_o),
  .q_frac_o    (q_frac_o),
  .rem_o       (rem_o),
  .rem_valid_o (rem_valid_o)
);

// File: tb/const_div_serial_test.sv
`timescale 1ns/1ps

module cds_lane #(
  parameter int P = 4
) (
  input  logic clk,
  input  logic rst_n,
  output int   errs,
  output int   checks,
  output logic done
);
  localparam int NMAX = 60 / P;
  localparam longint unsigned DV   = (64'd1 << P) + 64'd1;
  localparam longint unsigned MASK = (64'd1 << P) - 64'd1;

  logic         in_valid, in_ready, in_last;
  logic [P-1:0] in_tuple;
  logic [7:0]   frac_len;
  logic         q_valid, q_ready, q_frac, rem_valid;
  logic [P-1:0] q_tuple;
  logic [P:0]   rem;

  const_div_serial #(.P(P), .FLW(8)) uut (
    .clk_i(clk), .rst_ni(rst_n),
    .in_valid_i(in_valid), .in_ready_o(in_ready), .in_tuple_i(in_tuple),
    .in_last_i(in_last), .frac_len_i(frac_len),
    .q_valid_o(q_valid), .q_ready_i(q_ready), .q_tuple_o(q_tuple),
    .q_frac_o(q_frac), .rem_o(rem), .rem_valid_o(rem_valid)
  );

  longint unsigned exp_d[$];
  bit              exp_f[$];
  longint unsigned exp_r[$];
  int  prev_left = 0;
  bit  tb_first  = 0;
  bit  bp_en     = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint unsigned act, input longint unsigned expv);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s P=%0d %s: actual=%0d expected=%0d", req, P, what, act, expv);
    end
  endtask

  function automatic longint unsigned rnd_x(input int n);
    longint unsigned v;
    v = {$urandom(), $urandom()};
    return v & ((64'd1 << (n * P)) - 64'd1);
  endfunction

  task automatic run_op(input longint unsigned x, input int n, input int flen);
    longint unsigned q, r, r2;
    q = x / DV;
    r = x % DV;
    @(negedge clk);
    prev_left = exp_d.size();
    for (int i = n - 1; i >= 0; i--) begin
      exp_d.push_back((q >> (i * P)) & MASK);
      exp_f.push_back(1'b0);
    end
    r2 = r;
    for (int k = 0; k < flen; k++) begin
      r2 = r2 << P;
      exp_d.push_back(r2 / DV);
      exp_f.push_back(1'b1);
      r2 = r2 % DV;
    end
    exp_r.push_back(r);
    frac_len = 8'(flen);
    for (int i = n - 1; i >= 0; i--) begin
      in_valid = 1'b1;
      in_tuple = P'((x >> (i * P)) & MASK);
      in_last  = (i == 0);
      tb_first = (i == n - 1);
      #1;
      while (!in_ready) begin
        @(negedge clk);
        #1;
      end
      @(negedge clk);
    end
    in_valid = 1'b0;
    in_last  = 1'b0;
    tb_first = 1'b0;
  endtask

  task automatic drain(input string req);
    int c = 0;
    while ((exp_d.size() != 0 || q_valid) && c < 2000) begin
      @(negedge clk);
      c++;
    end
    repeat (3) @(negedge clk);
    chk(exp_d.size() == 0 && !q_valid, req, "outstanding tuples after drain",
        exp_d.size(), 0);
  endtask

  // output ready pattern
  initial begin
    q_ready = 1'b1;
    forever begin
      @(negedge clk);
      q_ready = bp_en ? ($urandom_range(0, 2) != 0) : 1'b1;
    end
  end

  // cycle monitor
  initial begin
    bit              held = 0, h_f = 0, rem_seen = 0, hs;
    longint unsigned h_d = 0, ed, er;
    bit              ef;
    forever begin
      @(negedge clk);
      #1;
      if (rst_n) begin
        hs = q_valid && q_ready;
        if (in_valid && in_ready && tb_first)
          chk(prev_left - int'(hs) == 0, "R8", "previous output pending at new dividend",
              longint'(prev_left - int'(hs)), 0);
        if (held)
          chk(q_valid && q_tuple == P'(h_d) && q_frac == h_f, "R9", "stalled output changed",
              longint'(q_tuple), h_d);
        held = q_valid && !q_ready;
        h_d  = longint'(q_tuple);
        h_f  = q_frac;
        if (hs) begin
          if (exp_d.size() == 0) begin
            chk(1'b0, "R7", "unexpected output tuple", longint'(q_tuple), 0);
          end else begin
            ed = exp_d.pop_front();
            ef = exp_f.pop_front();
            chk(q_frac == ef, "R5", "integer/fraction tag", longint'(q_frac), longint'(ef));
            if (ef) chk(longint'(q_tuple) == ed, "R5/R6", "fraction tuple", longint'(q_tuple), ed);
            else    chk(longint'(q_tuple) == ed, "R1/R2/R10", "quotient tuple", longint'(q_tuple), ed);
            if (prev_left > 0) prev_left--;
          end
        end
        if (!rem_valid) rem_seen = 0;
        else if (!rem_seen) begin
          rem_seen = 1;
          if (exp_r.size() == 0) chk(1'b0, "R4", "unexpected remainder", longint'(rem), 0);
          else begin
            er = exp_r.pop_front();
            chk(longint'(rem) == er, "R4", "integer remainder", longint'(rem), er);
          end
        end
      end
    end
  end

  initial begin
    longint unsigned k;
    int n;
    errs = 0; checks = 0; done = 0;
    in_valid = 0; in_last = 0; in_tuple = '0; frac_len = '0;
    wait (rst_n);
    @(negedge clk);
    #1;
    chk(!q_valid && !rem_valid && in_ready, "R3", "reset state (valid,remvalid,ready)",
        {61'd0, q_valid, rem_valid, in_ready}, 1);
    // nonzero remainder, long fraction
    run_op(rnd_x(4) | 64'd1, 4, 7);
    drain("R5");
    // exact multiple: remainder zero, fraction all zero
    k = {$urandom(), $urandom()} & ((64'd1 << (3 * P - 1)) - 64'd1);
    run_op(k * DV, 4, 5);
    drain("R6");
    // no fraction requested
    run_op(rnd_x(3), 3, 0);
    drain("R7");
    // longest dividend of all ones, with backpressure
    bp_en = 1;
    run_op((64'd1 << (NMAX * P)) - 64'd1, NMAX, 3);
    drain("R10");
    // back-to-back divisions exercise remainder clearing and fraction lockout
    for (int i = 0; i < 24; i++) begin
      n = $urandom_range(2, NMAX);
      bp_en = ($urandom_range(0, 1) == 1);
      run_op(rnd_x(n), n, $urandom_range(0, 9));
    end
    drain("R3");
    chk(exp_r.size() == 0, "R4", "remainders not reported", exp_r.size(), 0);
    done = 1;
  end
endmodule

module const_div_serial_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  int   e1, e2, e3, c1, c2, c3;
  logic d1, d2, d3;

  cds_lane #(.P(1)) lane_p1 (.clk(clk), .rst_n(rst_n), .errs(e1), .checks(c1), .done(d1));
  cds_lane #(.P(4)) lane_p4 (.clk(clk), .rst_n(rst_n), .errs(e2), .checks(c2), .done(d2));
  cds_lane #(.P(7)) lane_p7 (.clk(clk), .rst_n(rst_n), .errs(e3), .checks(c3), .done(d3));

  initial begin
    int cyc = 0;
    int errs, total;
    repeat (5) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    while (!(d1 && d2 && d3) && cyc < 100000) begin
      @(posedge clk);
      cyc++;
    end
    errs  = e1 + e2 + e3;
    total = c1 + c2 + c3;
    if (!(d1 && d2 && d3)) begin
      errs++;
      total++;
      $display("FAIL watchdog: actual=%0d expected=done", cyc);
    end
    $display("Result: errors=%0d of %0d checks", errs, total);
    $finish;
  end
endmodule